// File: doc/BRIEF.md
# Host-to-Coprocessor Bus Bridge

This block sits on the 16-bit host CPU bus and gives the host access to an 8-bit sound coprocessor. It decodes byte and word accesses to the coprocessor's RAM window, a bus-request register, a coprocessor reset register, a bank register loaded one bit per write, and a file of 16 I/O port bytes. It also holds the bus-grant state and the coprocessor reset state. The window RAM is modelled inside the block. The host can reach it only while the coprocessor is stopped and held off its bus.

Targets outside this block's scope are not serviced here. The sound-chip range raises a select strobe. Any access that matches no decoded target is handed on through a forward strobe, together with its address and data, so that a neighbouring block can complete it.

The host presents one access per cycle on `acc_*`. Every response is registered and appears after the next rising clock edge. The strobes and pulses (`rd_valid`, `anomaly`, `snd_sel`, `fwd_valid`, `snd_rst_pulse`, `cp_rst_pulse`) stay high for exactly that one cycle.

Top module: `cpb_bridge`

## Requirements
- R1: After system reset the block is in this state: `running` is 0, `cp_reset` is 1, `bank_base` is 0, all I/O port bytes, TH phases and delay counters are 0, and the bus-request read counter is 0.
- R2: A host address with bits 23:16 equal to 0xA0 and bit 14 clear hits the RAM window. The RAM index is the low RAM_AW bits of the address, and higher index bits mirror.
  - A write while `running` is 0 stores `acc_wdata[7:0]` for a byte access and `acc_wdata[15:8]` for a word access.
  - A write while `running` is 1 leaves the RAM unchanged and pulses `anomaly`.
- R3: A RAM-window read while `running` is 0 returns the stored byte in both halves of `rd_data`, with `rd_valid` high. A RAM-window read while `running` is 1 returns 0x0000 and pulses `anomaly`.
- R4: A write to 0xA11100 takes `acc_wdata[0]` for a byte access and `acc_wdata[8]` for a word access. `running` becomes the inverse of that bit.
- R5: A read of 0xA11100 returns an upper byte of 0x80 OR `running` and a lower byte equal to the read counter. The counter then increments, wrapping at 8 bits.
- R6: A write to 0xA11200 whose selected bit (bit 0 for byte, bit 8 for word) is 0 sets `cp_reset`, clears `running` and pulses `snd_rst_pulse`.
- R7: Writing selected bit 1 to 0xA11200 while `cp_reset` is 1 clears `cp_reset` and pulses both `snd_rst_pulse` and `cp_rst_pulse`. Writing 1 while `cp_reset` is 0 changes nothing and pulses nothing.
- R8: A write to an address matching 0xA06000 under mask 0xFF7F00 shifts the 9-bit bank register right by one and puts `acc_wdata[0]` into bit 8. `bank_base` equals the register shifted left by 15.
- R9: An address matching 0xA10000 under mask 0xFFFFE0 selects the I/O port with index `acc_addr[4:1]`.
  - Writes store `acc_wdata[7:0]`.
  - A read of index 0 returns HW_VER, index 1 returns `pad1_in`, and index 2 returns `pad2_in`.
  - Reads of every other index return the stored byte.
  - Every I/O read returns its byte in both halves of `rd_data`.
- R10: Each of ports 1 and 2 has a TH phase counter and a delay counter. The delay counter increments every cycle and saturates at all ones. A port write that takes stored bit 6 from 0 to 1 increments that port's TH phase (wrapping) and clears its delay counter; the clear wins over that cycle's increment. Any other port write leaves both counters unaffected.
- R11: The sound range is a window address with bit 14 set and bit 13 clear. Any access there pulses `snd_sel`, and reads there return 0x0000. A read in the window that falls outside RAM and outside the sound range, including the bank address, returns 0xFFFF and pulses `anomaly`.
- R12: The following accesses pulse `fwd_valid` and present the access's address, data, direction and size on `fwd_*`:
  - accesses outside the 0xA0 window that match no register or port;
  - window writes that match no target;
  - reads of 0xA11200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_addr | input | 24 | Host byte address |
| acc_wdata | input | 16 | Host write data |
| pad1_in | input | 8 | Controller input read at port 1 |
| pad2_in | input | 8 | Controller input read at port 2 |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read response valid |
| running | output | 1 | Coprocessor owns its bus |
| cp_reset | output | 1 | Coprocessor held in reset |
| snd_rst_pulse | output | 1 | Sound-chip reset strobe |
| cp_rst_pulse | output | 1 | Coprocessor reset strobe on release |
| bank_base | output | 24 | Host-side bank base address |
| th_phase1 | output | PH_W | TH phase counter, port 1 |
| th_phase2 | output | PH_W | TH phase counter, port 2 |
| pad_dly1 | output | DLY_W | Delay counter, port 1 |
| pad_dly2 | output | DLY_W | Delay counter, port 2 |
| snd_sel | output | 1 | Sound-chip range select strobe |
| anomaly | output | 1 | Locked or unmapped window access |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded direction |
| fwd_word | output | 1 | Forwarded size |
| fwd_addr | output | 24 | Forwarded address |
| fwd_wdata | output | 16 | Forwarded write data |

## Verification
The delay counter of ports 1 and 2 advances on every clock, and a rising bit-6 write to the same port clears it in the same cycle. The bench provokes this collision by writing 0x40 over a stored 0x00 while the counter is running. It then judges the result in two steps: the delay counter reads 0 right after that edge and 1 one idle cycle later, and the phase counter has moved by exactly one. A second case also falls in a single cycle: a bus-request read both returns the counter value and increments it. The bench checks that each read returns the value from before that read's own increment.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

  typedef enum logic [2:0] {
    TGT_FWD,
    TGT_RAM,
    TGT_SND,
    TGT_BANK,
    TGT_IO,
    TGT_BREQ,
    TGT_RST,
    TGT_WIN
  } tgt_e;

  localparam logic [23:0] BREQ_ADDR = 24'hA11100;
  localparam logic [23:0] HOLD_ADDR = 24'hA11200;

  // Decode priority: RAM window, sound range, bank, ports, registers,
  // rest of window, everything else.
  function automatic tgt_e cpb_decode(input logic [23:0] a);
    tgt_e t;
    if      ((a & 24'hFF4000) == 24'hA00000) t = TGT_RAM;
    else if ((a & 24'hFF6000) == 24'hA04000) t = TGT_SND;
    else if ((a & 24'hFF7F00) == 24'hA06000) t = TGT_BANK;
    else if ((a & 24'hFFFFE0) == 24'hA10000) t = TGT_IO;
    else if (a == BREQ_ADDR)                 t = TGT_BREQ;
    else if (a == HOLD_ADDR)                 t = TGT_RST;
    else if (a[23:16] == 8'hA0)              t = TGT_WIN;
    else                                     t = TGT_FWD;
    return t;
  endfunction

endpackage

// File: rtl/cpb_ram.sv
module cpb_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cpb_ctrl.sv
module cpb_ctrl #(
  parameter int BANK_W = 9,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              breq_we,
  input  logic              breq_re,
  input  logic              hold_we,
  input  logic              bank_we,
  input  logic              sel_bit,
  input  logic              bank_bit,
  output logic              running_o,
  output logic              hold_o,
  output logic              snd_rst_o,
  output logic              cp_rst_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              run_q, run_d;
  logic              hold_q, hold_d;
  logic              snd_q, snd_d;
  logic              cpr_q, cpr_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    snd_d  = 1'b0;
    cpr_d  = 1'b0;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (breq_we) begin
      run_d = ~sel_bit;
    end
    if (hold_we) begin
      if (!sel_bit) begin
        hold_d = 1'b1;
        run_d  = 1'b0;
        snd_d  = 1'b1;
      end else if (hold_q) begin
        hold_d = 1'b0;
        snd_d  = 1'b1;
        cpr_d  = 1'b1;
      end
    end
    if (bank_we) begin
      bank_d = {bank_bit, bank_q[BANK_W-1:1]};
    end
    if (breq_re) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b1;
      snd_q  <= 1'b0;
      cpr_q  <= 1'b0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
      snd_q  <= snd_d;
      cpr_q  <= cpr_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  assign running_o = run_q;
  assign hold_o    = hold_q;
  assign snd_rst_o = snd_q;
  assign cp_rst_o  = cpr_q;
  assign bank_o    = bank_q;
  assign cnt_o     = cnt_q;

  // R6
  a_r6_hold_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && !sel_bit) |=> (hold_q && !run_q && snd_q));

  // R7
  a_r7_release_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    cpr_q |-> (snd_q && !hold_q && $past(hold_q)));

  // R8
  a_r8_bank_shift: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1])));

  // R5
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    breq_re |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/cpb_ioport.sv
module cpb_ioport #(
  parameter int         IDX_W  = 4,
  parameter int         PH_W   = 2,
  parameter int         DLY_W  = 4,
  parameter logic [7:0] HW_VER = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  logic [7:0]       pad1_in,
  input  logic [7:0]       pad2_in,
  output logic [7:0]       rdata,
  output logic [PH_W-1:0]  phase1_o,
  output logic [PH_W-1:0]  phase2_o,
  output logic [DLY_W-1:0] dly1_o,
  output logic [DLY_W-1:0] dly2_o
);
  localparam int NPORT = 1 << IDX_W;
  localparam int NPAD  = 2;
  localparam int TH_BIT = 6;

  logic [NPORT-1:0][7:0]    port_q, port_d;
  logic [NPAD-1:0][PH_W-1:0]  ph_q, ph_d;
  logic [NPAD-1:0][DLY_W-1:0] dly_q, dly_d;
  logic [NPAD-1:0]            rise;

  always_comb begin
    port_d = port_q;
    if (we) begin
      port_d[idx] = wdata;
    end
  end

  for (genvar k = 0; k < NPAD; k++) begin : g_pad
    assign rise[k] = we && (idx == IDX_W'(k + 1)) &&
                     !port_q[k + 1][TH_BIT] && wdata[TH_BIT];

    always_comb begin
      ph_d[k]  = ph_q[k];
      dly_d[k] = dly_q[k];
      if (rise[k]) begin
        ph_d[k]  = ph_q[k] + PH_W'(1);
        dly_d[k] = '0;
      end else if (dly_q[k] != {DLY_W{1'b1}}) begin
        dly_d[k] = dly_q[k] + DLY_W'(1);
      end
    end

    // R10
    a_r10_phase_clears_dly: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q[k] != $past(ph_q[k])) |-> (dly_q[k] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      ph_q   <= '0;
      dly_q  <= '0;
    end else begin
      port_q <= port_d;
      ph_q   <= ph_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_W'(0): rdata = HW_VER;
      IDX_W'(1): rdata = pad1_in;
      IDX_W'(2): rdata = pad2_in;
      default:   rdata = port_q[idx];
    endcase
  end

  assign phase1_o = ph_q[0];
  assign phase2_o = ph_q[1];
  assign dly1_o   = dly_q[0];
  assign dly2_o   = dly_q[1];

endmodule

// File: rtl/cpb_bridge.sv
module cpb_bridge
  import cpb_pkg::*;
#(
  parameter int         RAM_AW = 11,
  parameter int         BANK_W = 9,
  parameter int         PH_W   = 2,
  parameter int         DLY_W  = 4,
  parameter logic [7:0] HW_VER = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_word,
  input  logic [23:0]      acc_addr,
  input  logic [15:0]      acc_wdata,
  input  logic [7:0]       pad1_in,
  input  logic [7:0]       pad2_in,
  output logic [15:0]      rd_data,
  output logic             rd_valid,
  output logic             running,
  output logic             cp_reset,
  output logic             snd_rst_pulse,
  output logic             cp_rst_pulse,
  output logic [23:0]      bank_base,
  output logic [PH_W-1:0]  th_phase1,
  output logic [PH_W-1:0]  th_phase2,
  output logic [DLY_W-1:0] pad_dly1,
  output logic [DLY_W-1:0] pad_dly2,
  output logic             snd_sel,
  output logic             anomaly,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic             fwd_word,
  output logic [23:0]      fwd_addr,
  output logic [15:0]      fwd_wdata
);
  localparam int BASE_SHIFT = 15;
  localparam int CNT_W      = 8;
  localparam int IDX_W      = 4;

  tgt_e              tgt;
  logic              rd, wr, sel_bit;
  logic              ram_we;
  logic [7:0]        ram_wbyte, ram_rbyte, io_rbyte;
  logic [BANK_W-1:0] bank;
  logic [CNT_W-1:0]  cnt;
  logic              run_w;

  logic [15:0] rdat_q, rdat_d;
  logic        rval_q, rval_d;
  logic        anom_q, anom_d;
  logic        snd_q, snd_d;
  logic        fv_q, fv_d;
  logic        fw_q, fwd_word_q;
  logic [23:0] fa_q;
  logic [15:0] fd_q;

  assign tgt       = cpb_decode(acc_addr);
  assign rd        = acc_valid && !acc_write;
  assign wr        = acc_valid && acc_write;
  assign sel_bit   = acc_word ? acc_wdata[8] : acc_wdata[0];
  assign ram_we    = wr && (tgt == TGT_RAM) && !run_w;
  assign ram_wbyte = acc_word ? acc_wdata[15:8] : acc_wdata[7:0];

  cpb_ram #(.AW(RAM_AW)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (acc_addr[RAM_AW-1:0]),
    .wdata (ram_wbyte),
    .raddr (acc_addr[RAM_AW-1:0]),
    .rdata (ram_rbyte)
  );

  cpb_ctrl #(.BANK_W(BANK_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .breq_we   (wr && (tgt == TGT_BREQ)),
    .breq_re   (rd && (tgt == TGT_BREQ)),
    .hold_we   (wr && (tgt == TGT_RST)),
    .bank_we   (wr && (tgt == TGT_BANK)),
    .sel_bit   (sel_bit),
    .bank_bit  (acc_wdata[0]),
    .running_o (run_w),
    .hold_o    (cp_reset),
    .snd_rst_o (snd_rst_pulse),
    .cp_rst_o  (cp_rst_pulse),
    .bank_o    (bank),
    .cnt_o     (cnt)
  );

  cpb_ioport #(.IDX_W(IDX_W), .PH_W(PH_W), .DLY_W(DLY_W), .HW_VER(HW_VER)) io_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr && (tgt == TGT_IO)),
    .idx      (acc_addr[IDX_W:1]),
    .wdata    (acc_wdata[7:0]),
    .pad1_in  (pad1_in),
    .pad2_in  (pad2_in),
    .rdata    (io_rbyte),
    .phase1_o (th_phase1),
    .phase2_o (th_phase2),
    .dly1_o   (pad_dly1),
    .dly2_o   (pad_dly2)
  );

  always_comb begin
    rdat_d = rdat_q;
    rval_d = rd;
    anom_d = 1'b0;
    snd_d  = acc_valid && (tgt == TGT_SND);
    fv_d   = 1'b0;
    if (rd) begin
      case (tgt)
        TGT_RAM:  rdat_d = run_w ? 16'h0000 : {ram_rbyte, ram_rbyte};
        TGT_IO:   rdat_d = {io_rbyte, io_rbyte};
        TGT_BREQ: rdat_d = {7'b1000000, run_w, cnt};
        TGT_WIN,
        TGT_BANK: rdat_d = 16'hFFFF;
        default:  rdat_d = 16'h0000;
      endcase
    end
    if (acc_valid && (tgt == TGT_RAM) && run_w) begin
      anom_d = 1'b1;
    end
    if (rd && ((tgt == TGT_WIN) || (tgt == TGT_BANK))) begin
      anom_d = 1'b1;
    end
    if (acc_valid && ((tgt == TGT_FWD) || (wr && (tgt == TGT_WIN)) ||
                      (rd && (tgt == TGT_RST)))) begin
      fv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q     <= '0;
      rval_q     <= 1'b0;
      anom_q     <= 1'b0;
      snd_q      <= 1'b0;
      fv_q       <= 1'b0;
      fw_q       <= 1'b0;
      fwd_word_q <= 1'b0;
      fa_q       <= '0;
      fd_q       <= '0;
    end else begin
      rdat_q <= rdat_d;
      rval_q <= rval_d;
      anom_q <= anom_d;
      snd_q  <= snd_d;
      fv_q   <= fv_d;
      if (fv_d) begin
        fw_q       <= acc_write;
        fwd_word_q <= acc_word;
        fa_q       <= acc_addr;
        fd_q       <= acc_wdata;
      end
    end
  end

  assign rd_data   = rdat_q;
  assign rd_valid  = rval_q;
  assign running   = run_w;
  assign bank_base = 24'({bank, {BASE_SHIFT{1'b0}}});
  assign snd_sel   = snd_q;
  assign anomaly   = anom_q;
  assign fwd_valid = fv_q;
  assign fwd_write = fw_q;
  assign fwd_word  = fwd_word_q;
  assign fwd_addr  = fa_q;
  assign fwd_wdata = fd_q;

  // R2
  a_r2_locked_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (acc_addr[23:16] == 8'hA0) && !acc_addr[14] && running)
      |=> anomaly);

  // R3
  a_r3_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && (acc_addr[23:16] == 8'hA0) && !acc_addr[14] && running)
      |=> (rd_valid && (rd_data == 16'h0000) && anomaly));

  // R12
  a_r12_fwd_not_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[23:16] == 8'hA0) && !acc_addr[14]) |=> !fwd_valid);

endmodule

// File: tb/cpb_bridge_tb.sv
module cpb_bridge_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         RAM_AW     = 11;
  localparam logic [7:0] HW_VER     = 8'h20;

  logic        clk, rst_n;
  logic        acc_valid, acc_write, acc_word;
  logic [23:0] acc_addr;
  logic [15:0] acc_wdata;
  logic [7:0]  pad1_in, pad2_in;
  logic [15:0] rd_data;
  logic        rd_valid, running, cp_reset, snd_rst_pulse, cp_rst_pulse;
  logic [23:0] bank_base;
  logic [1:0]  th_phase1, th_phase2;
  logic [3:0]  pad_dly1, pad_dly2;
  logic        snd_sel, anomaly, fwd_valid, fwd_write, fwd_word;
  logic [23:0] fwd_addr;
  logic [15:0] fwd_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cpb_bridge #(.RAM_AW(RAM_AW), .BANK_W(9), .PH_W(2), .DLY_W(4), .HW_VER(HW_VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .pad1_in(pad1_in), .pad2_in(pad2_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .running(running), .cp_reset(cp_reset), .snd_rst_pulse(snd_rst_pulse),
    .cp_rst_pulse(cp_rst_pulse), .bank_base(bank_base), .th_phase1(th_phase1),
    .th_phase2(th_phase2), .pad_dly1(pad_dly1), .pad_dly2(pad_dly2),
    .snd_sel(snd_sel), .anomaly(anomaly), .fwd_valid(fwd_valid),
    .fwd_write(fwd_write), .fwd_word(fwd_word), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access; returns just after the edge that registers its response.
  task automatic acc(input logic w, input logic word, input logic [23:0] a,
                     input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_word = word; acc_addr = a; acc_wdata = d;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       exp_run;
    logic [7:0] exp_cnt;
    logic [8:0] exp_bank;
    logic [1:0] exp_ph1;
    acc_valid = 0; acc_write = 0; acc_word = 0; acc_addr = '0; acc_wdata = '0;
    pad1_in = 8'h5A; pad2_in = 8'hC3;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 running", running, 0);
    chk("R1 cp_reset", cp_reset, 1);
    chk("R1 bank_base", bank_base, 0);
    chk("R1 phases", {th_phase1, th_phase2}, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 fwd_valid", fwd_valid, 0);

    // R5 (and R1 counter reset): bus-request reads
    exp_run = 0; exp_cnt = 0;
    for (int k = 0; k < 5; k++) begin
      acc(0, k[0], 24'hA11100, 16'h0);
      chk("R5 breq read", rd_data, {7'b1000000, exp_run, exp_cnt});
      exp_cnt++;
    end

    // R4 bus request writes
    acc(1, 0, 24'hA11100, 16'h0000); chk("R4 byte 0 runs", running, 1);
    acc(1, 0, 24'hA11100, 16'h0001); chk("R4 byte 1 stops", running, 0);
    acc(1, 1, 24'hA11100, 16'h00FE); chk("R4 word bit8=0 runs", running, 1);
    acc(1, 1, 24'hA11100, 16'h0100); chk("R4 word bit8=1 stops", running, 0);
    acc(1, 1, 24'hA11100, 16'hFEFF); chk("R4 word ignores bit0", running, 1);
    acc(0, 1, 24'hA11100, 16'h0);
    chk("R5 read reflects run", rd_data, {7'b1000000, 1'b1, exp_cnt});
    exp_cnt++;
    acc(1, 0, 24'hA11100, 16'h0001);

    // R2/R3 RAM sweep with running == 0
    for (int i = 0; i < 256; i++) begin
      if (i[0]) acc(1, 1, 24'hA00000 | 24'(i * 8), {pat(i), ~pat(i)});
      else      acc(1, 0, 24'hA00000 | 24'(i * 8), {8'hEE, pat(i)});
      chk("R2 write no anomaly", anomaly, 0);
    end
    for (int i = 0; i < 256; i++) begin
      acc(0, 1, 24'hA00000 | 24'(i * 8), 16'h0);
      chk("R3 ram readback", {rd_valid, rd_data}, {1'b1, pat(i), pat(i)});
    end
    acc(0, 0, 24'hA00000 | 24'(1 << RAM_AW), 16'h0);
    chk("R2 index mirror", rd_data, {pat(0), pat(0)});

    // R2/R3 locked while running
    acc(1, 0, 24'hA11100, 16'h0000);
    acc(1, 0, 24'hA00000, 16'h0055);
    chk("R2 locked write anomaly", anomaly, 1);
    acc(0, 1, 24'hA00000, 16'h0);
    chk("R3 locked read", {anomaly, rd_valid, rd_data}, {2'b11, 16'h0000});
    acc(1, 0, 24'hA11100, 16'h0001);
    acc(0, 1, 24'hA00000, 16'h0);
    chk("R2 locked write ignored", {anomaly, rd_data}, {1'b0, pat(0), pat(0)});

    // R6/R7 reset register
    acc(1, 0, 24'hA11200, 16'h0001);
    chk("R7 release", {cp_reset, snd_rst_pulse, cp_rst_pulse}, 3'b011);
    acc(1, 0, 24'hA11200, 16'h0001);
    chk("R7 no effect", {cp_reset, snd_rst_pulse, cp_rst_pulse}, 3'b000);
    acc(1, 0, 24'hA11100, 16'h0000);
    chk("R4 run before hold", running, 1);
    acc(1, 1, 24'hA11200, 16'h00FF);
    chk("R6 word hold", {cp_reset, running, snd_rst_pulse, cp_rst_pulse}, 4'b1010);
    acc(1, 1, 24'hA11200, 16'h0100);
    chk("R7 word release", {cp_reset, snd_rst_pulse, cp_rst_pulse}, 3'b011);
    acc(1, 0, 24'hA11200, 16'h0000);
    chk("R6 byte hold", {cp_reset, snd_rst_pulse, cp_rst_pulse}, 3'b110);

    // R8 bank register
    exp_bank = 0;
    for (int k = 0; k < 12; k++) begin
      logic b;
      b = 1'((12'hA5B >> k) & 1);
      acc(1, k[0], 24'hA06000 | 24'(k * 5) | (k[1] ? 24'h008000 : 24'h0), {15'h7FFE, b});
      exp_bank = {b, exp_bank[8:1]};
      chk("R8 bank shift", bank_base, {exp_bank, 15'b0});
    end

    // R9 I/O ports
    for (int i = 0; i < 16; i++) begin
      acc(1, i[0], 24'hA10000 | 24'(i * 2) | 24'(i[1]), {8'hFF, 8'(i * 17 + 5)});
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = (i == 0) ? HW_VER : (i == 1) ? pad1_in : (i == 2) ? pad2_in : 8'(i * 17 + 5);
      acc(0, 1, 24'hA10000 | 24'(i * 2), 16'h0);
      chk("R9 port read", rd_data, {e, e});
    end
    chk("R10 no rise yet", {th_phase1, th_phase2}, 0);

    // R10 TH phase and delay
    acc(1, 0, 24'hA10002, 16'h0000);
    acc(1, 0, 24'hA10002, 16'h0040);
    chk("R10 rise phase1", th_phase1, 1);
    chk("R10 rise clears dly1", pad_dly1, 0);
    idle();
    chk("R10 dly1 counts", pad_dly1, 1);
    acc(1, 0, 24'hA10002, 16'h0040);
    chk("R10 no rise keeps phase", th_phase1, 1);
    chk("R10 no rise keeps count", pad_dly1, 2);
    chk("R10 port2 untouched", th_phase2, 0);
    exp_ph1 = 1;
    for (int k = 0; k < 4; k++) begin
      acc(1, 0, 24'hA10002, 16'h0000);
      acc(1, 1, 24'hA10003, 16'hFF4F);
      exp_ph1++;
      chk("R10 phase1 wrap", th_phase1, exp_ph1);
    end
    acc(1, 0, 24'hA10004, 16'h0040);
    chk("R10 rise phase2", {th_phase2, pad_dly2}, {2'd1, 4'd0});
    repeat (20) idle();
    chk("R10 dly saturates", {pad_dly1, pad_dly2}, 8'hFF);

    // R11 window reads outside RAM and sound range
    acc(0, 1, 24'hA07000, 16'h0);
    chk("R11 unmapped read", {anomaly, rd_data}, {1'b1, 16'hFFFF});
    acc(0, 0, 24'hA06000, 16'h0);
    chk("R11 bank read", {anomaly, rd_data}, {1'b1, 16'hFFFF});
    acc(0, 1, 24'hA04000, 16'h0);
    chk("R11 sound read", {snd_sel, anomaly, rd_data}, {2'b10, 16'h0000});
    acc(1, 0, 24'hA05FFF, 16'h0012);
    chk("R11 sound write", {snd_sel, fwd_valid}, 2'b10);

    // R12 forwarding
    acc(1, 1, 24'hC00000, 16'h1234);
    chk("R12 fwd write", {fwd_valid, fwd_write, fwd_word, fwd_addr, fwd_wdata},
        {3'b111, 24'hC00000, 16'h1234});
    acc(0, 0, 24'hA11200, 16'h0);
    chk("R12 fwd hold read", {fwd_valid, fwd_write, fwd_word, fwd_addr},
        {3'b100, 24'hA11200});
    acc(1, 0, 24'hA07F11, 16'h009F);
    chk("R12 fwd window write", {fwd_valid, fwd_addr, anomaly}, {1'b1, 24'hA07F11, 1'b0});
    idle();
    chk("R12 fwd strobe one cycle", fwd_valid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule